// File: doc/BRIEF.md
# Timer clock select prescaler

This block turns a 3-bit clock select field into a count-enable pulse for a timer/counter. The pulse is one system clock wide. Depending on the select code, it comes from a free-running prescaler that divides the system clock by one of a fixed set of ratios, or from edges seen on an external pin. A counter placed downstream increments only in cycles where the pulse is high. Code zero stops that counter.

The external pin passes through a synchroniser and an edge detector. The pin level is sampled no matter what drives it. If the pin is configured as an output, software can still advance the counter by toggling it. The prescaler is shared by all divided modes. It is never restarted by a change of select, so changing the ratio moves the pulse onto the new ratio's grid with no extra latency.

Top module: `tick_prescaler_sel`

## Requirements
- R1: While `rst_ni` is low, `tick_o` is 0 and the prescaler is held at zero.
- R2: With select code 0, `tick_o` stays 0 and the timer is stopped.
- R3: With select code 1, `tick_o` is 1 after every rising clock edge, so there is no prescaling.
- R4: Codes 2, 3, 4 and 5 select division ratios N of 8, 64, 256 and 1024. Number the rising edges after reset release from 1. `tick_o` is high after edge k exactly when k is a multiple of N. At that edge the low log2(N) bits of the 10-bit prescaler were all ones.
- R5: With select code 6, a falling pin transition made between two clock edges raises `tick_o` after the third rising edge that follows it.
- R6: With select code 7, a rising pin transition raises `tick_o` after the third rising edge that follows it. Falling transitions give no pulse.
- R7: Each pin edge gives exactly one pulse, one clock wide. A pin that is held at either level gives no further pulses.
- R8: A new select value governs the pulse from the first clock edge at which it is present. The prescaler keeps counting through the change and is not cleared by it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 3 | Clock select code (0 stop, 1 to 5 divided, 6 falling pin, 7 rising pin) |
| ext_pin_i | input | 1 | External pin level, asynchronous to the clock |
| tick_o | output | 1 | One-cycle count enable |

## Verification
Each divided code is held long enough to show several pulses. Code 5 is held across more than one prescaler wrap. A wrong ratio or a wrong tap shows up as a pulse at the wrong edge number. A run of random select changes, with a directed 64-to-8 switch in the middle, separates a prescaler that keeps running from one that restarts on a select change. In the pin modes, the pin is driven with random toggles and with long held levels. This catches a swapped polarity, a wrong synchroniser depth, and a pulse that is level-sensitive or longer than one cycle.

// File: rtl/tick_sel_pkg.sv
package tick_sel_pkg;

  typedef enum logic [2:0] {
    SEL_OFF      = 3'd0,
    SEL_DIV1     = 3'd1,
    SEL_DIV8     = 3'd2,
    SEL_DIV64    = 3'd3,
    SEL_DIV256   = 3'd4,
    SEL_DIV1024  = 3'd5,
    SEL_PIN_FALL = 3'd6,
    SEL_PIN_RISE = 3'd7
  } sel_e;

  // Number of low prescaler bits that must be all ones for a divided pulse.
  function automatic int unsigned tap_bits(sel_e s);
    case (s)
      SEL_DIV8:    return 3;
      SEL_DIV64:   return 6;
      SEL_DIV256:  return 8;
      SEL_DIV1024: return 10;
      default:     return 0;
    endcase
  endfunction

  // True when the low 'bits' bits of cnt are all ones.
  function automatic logic low_bits_full(logic [31:0] cnt, int unsigned bits);
    logic [31:0] m;
    m = (32'd1 << bits) - 32'd1;
    return (cnt & m) == m;
  endfunction

endpackage

// File: rtl/presc_counter.sv
module presc_counter #(
  parameter int unsigned CNT_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [CNT_W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_o <= '0;
    else         cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/pin_edge_detect.sv
module pin_edge_detect #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);
  localparam int unsigned CHAIN = SYNC_STAGES + 1;

  logic [CHAIN-1:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q[0] <= 1'b0;
    else         stage_q[0] <= pin_i;
  end

  for (genvar g = 1; g < CHAIN; g++) begin : g_chain
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[g] <= 1'b0;
      else         stage_q[g] <= stage_q[g-1];
    end
  end

  // Synchronised level versus the level one cycle earlier.
  assign rise_o =  stage_q[CHAIN-2] & ~stage_q[CHAIN-1];
  assign fall_o = ~stage_q[CHAIN-2] &  stage_q[CHAIN-1];
endmodule

// File: rtl/tick_mux.sv
module tick_mux
  import tick_sel_pkg::*;
#(
  parameter int unsigned CNT_W = 10
) (
  input  logic [2:0]       sel_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             rise_i,
  input  logic             fall_i,
  output logic             div_hit_o,
  output logic             tick_d_o
);
  sel_e sel;
  assign sel = sel_e'(sel_i);

  always_comb begin
    div_hit_o = low_bits_full(32'(cnt_i), tap_bits(sel));
    case (sel)
      SEL_OFF:      tick_d_o = 1'b0;
      SEL_DIV1:     tick_d_o = 1'b1;
      SEL_PIN_FALL: tick_d_o = fall_i;
      SEL_PIN_RISE: tick_d_o = rise_i;
      default:      tick_d_o = div_hit_o;
    endcase
  end
endmodule

// File: rtl/tick_prescaler_sel.sv
module tick_prescaler_sel #(
  parameter int unsigned CNT_W       = 10,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] sel_i,
  input  logic       ext_pin_i,
  output logic       tick_o
);
  logic [CNT_W-1:0] presc_cnt;
  logic             pin_rise;
  logic             pin_fall;
  logic             div_hit;
  logic             tick_d;

  presc_counter #(.CNT_W(CNT_W)) u_presc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .cnt_o (presc_cnt)
  );

  pin_edge_detect #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .pin_i (ext_pin_i),
    .rise_o(pin_rise),
    .fall_o(pin_fall)
  );

  tick_mux #(.CNT_W(CNT_W)) u_mux (
    .sel_i    (sel_i),
    .cnt_i    (presc_cnt),
    .rise_i   (pin_rise),
    .fall_i   (pin_fall),
    .div_hit_o(div_hit),
    .tick_d_o (tick_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tick_o <= 1'b0;
    else         tick_o <= tick_d;
  end
endmodule

// File: rtl/tick_prescaler_sel_chk.sv
module tick_prescaler_sel_chk #(
  parameter int unsigned CNT_W = 10
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [2:0]       sel_i,
  input logic             tick_o,
  input logic [CNT_W-1:0] presc_cnt,
  input logic             pin_rise,
  input logic             pin_fall
);
  assert_reset_clear_R1: assert property (@(posedge clk_i)
    !rst_ni |=> (!tick_o && presc_cnt == '0));

  assert_stop_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == 3'd0) |=> !tick_o);

  assert_every_clock_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == 3'd1) |=> tick_o);

  assert_div8_gap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == 3'd2 && presc_cnt[2:0] != 3'b111) |=> !tick_o);

  assert_div1024_hit_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == 3'd5 && presc_cnt[9:0] == 10'h3ff) |=> tick_o);

  assert_fall_tick_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == 3'd6) |=> (tick_o == $past(pin_fall)));

  assert_rise_tick_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == 3'd7) |=> (tick_o == $past(pin_rise)));

  assert_edge_exclusive_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pin_rise && pin_fall));

  assert_presc_free_run_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (presc_cnt == CNT_W'($past(presc_cnt) + 1'b1)));
endmodule

bind tick_prescaler_sel tick_prescaler_sel_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .sel_i    (sel_i),
  .tick_o   (tick_o),
  .presc_cnt(presc_cnt),
  .pin_rise (pin_rise),
  .pin_fall (pin_fall)
);

// File: tb/tick_prescaler_sel_test.sv
module tick_prescaler_sel_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [2:0] sel_i = 3'd0;
  logic       ext_pin_i = 1'b0;
  logic       tick_o;

  int    n_vec = 0;
  int    n_bad = 0;
  bit    checking = 1'b0;
  string tag_force = "";

  // Reference state: edges since reset and pin samples 1, 2, 3 edges back.
  int   edge_no = 0;
  logic pin_ago1 = 1'b0, pin_ago2 = 1'b0, pin_ago3 = 1'b0;
  logic exp_tick = 1'b0;

  always #4 clk_i = ~clk_i;

  tick_prescaler_sel uut (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sel_i    (sel_i),
    .ext_pin_i(ext_pin_i),
    .tick_o   (tick_o)
  );

  function automatic int ratio_of(logic [2:0] s);
    case (s)
      3'd2: return 8;
      3'd3: return 64;
      3'd4: return 256;
      3'd5: return 1024;
      default: return 1;
    endcase
  endfunction

  function automatic logic expect_tick(logic [2:0] s, int k, logic older, logic oldest);
    case (s)
      3'd0: return 1'b0;
      3'd1: return 1'b1;
      3'd6: return !older && oldest;
      3'd7: return older && !oldest;
      default: return (k % ratio_of(s)) == 0;
    endcase
  endfunction

  function automatic string tag_of(logic [2:0] s);
    case (s)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd6: return "R5";
      3'd7: return "R6";
      default: return "R4";
    endcase
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      edge_no = 0; pin_ago1 = 0; pin_ago2 = 0; pin_ago3 = 0; exp_tick = 0;
    end else begin
      edge_no  = edge_no + 1;
      exp_tick = expect_tick(sel_i, edge_no, pin_ago2, pin_ago3);
      pin_ago3 = pin_ago2;
      pin_ago2 = pin_ago1;
      pin_ago1 = ext_pin_i;
    end
  end

  task automatic check(string tag, logic act, logic exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: tick_o=%0b expected %0b (edge %0d, sel %0d)",
               tag, act, exp, edge_no, sel_i);
    end
  endtask

  always @(negedge clk_i) begin
    if (checking)
      check(tag_force != "" ? tag_force : tag_of(sel_i), tick_o, exp_tick);
  end

  task automatic run(logic [2:0] s, int cycles);
    sel_i = s;
    repeat (cycles) @(negedge clk_i);
  endtask

  task automatic pin_edge_count(logic [2:0] s, logic lvl);
    int seen = 0;
    sel_i = s;
    ext_pin_i = !lvl;
    repeat (6) @(negedge clk_i);
    ext_pin_i = lvl;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk_i);
      if (tick_o) seen++;
    end
    n_vec++;
    if (seen != 1) begin
      n_bad++;
      $display("FAIL R7: %0d pulses for one pin edge, expected 1", seen);
    end
  endtask

  initial begin : watchdog
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd20240611));
    sel_i = 3'd1;
    repeat (4) @(negedge clk_i);
    check("R1", tick_o, 1'b0);
    rst_ni = 1'b1;
    checking = 1'b1;
    run(3'd1, 20);
    run(3'd0, 40);
    run(3'd2, 100);
    run(3'd3, 200);
    run(3'd4, 600);
    run(3'd5, 2200);
    // R8: switch ratio mid-count, prescaler must keep its phase.
    tag_force = "R8";
    run(3'd3, 37);
    run(3'd2, 60);
    run(3'd5, 5);
    run(3'd3, 140);
    tag_force = "";
    // R5/R6 with random toggles and held levels.
    sel_i = 3'd6;
    for (int i = 0; i < 400; i++) begin
      ext_pin_i = (i % 100 < 70) ? 1'($urandom) : ext_pin_i;
      @(negedge clk_i);
    end
    sel_i = 3'd7;
    for (int i = 0; i < 400; i++) begin
      ext_pin_i = (i % 100 < 70) ? 1'($urandom) : ext_pin_i;
      @(negedge clk_i);
    end
    tag_force = "R7";
    pin_edge_count(3'd7, 1'b1);
    pin_edge_count(3'd6, 1'b0);
    tag_force = "R8";
    for (int i = 0; i < 2000; i++) begin
      sel_i = 3'($urandom);
      if ($urandom % 4 == 0) ext_pin_i = ~ext_pin_i;
      @(negedge clk_i);
    end
    tag_force = "";
    // R1: reset mid-run clears the output and restarts the phase.
    sel_i = 3'd2;
    checking = 1'b0;
    rst_ni = 1'b0;
    @(negedge clk_i);
    check("R1", tick_o, 1'b0);
    rst_ni = 1'b1;
    checking = 1'b1;
    run(3'd2, 50);
    checking = 1'b0;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule